// File: doc/BRIEF.md
# Flash Chip-Select Envelope Generator

This block wraps every serial flash operation in a chip-select envelope and gates the serial clock inside it. When a phase sequencer raises a start request while the block is ready, the block drives the chosen device's select line low. It waits a programmed setup interval and then enables the serial clock. The clock stays enabled until the sequencer flags the last bit. A programmed hold interval follows with the select line still low. The line is then released, and a programmed minimum deselect interval must pass before the block reports ready again.

The three intervals come from a single 12-bit timing register, written through a strobe. Each interval is a 4-bit count of controller clock cycles. Two select lines are provided, and an index sampled together with the start request picks which line is driven. The other line stays high.

Top module: `cst_gen`

## Requirements
- R1: After reset both `cs_n` lines are high, `sclk_en` is low and `ready` is high. The timing register resets to setup 6, hold 6 and deselect 15.
- R2: A `start_req` sampled high while `ready` is high is accepted. From the next cycle `ready` is low and only `cs_n[cs_index]` is low, where index 0 selects bit 0. The other line stays high throughout.
- R3: After acceptance the select line is low and `sclk_en` is low for max(setup,1) cycles. Setup is timing register bits 7:4.
- R4: `sclk_en` is high from the end of setup up to and including the cycle in which `last_bit` is sampled high.
- R5: After that cycle the select line stays low with `sclk_en` low for max(hold,1) cycles. Hold is timing register bits 11:8.
- R6: Both lines are then high and `ready` is low for max(deselect,1) cycles. Deselect is timing register bits 3:0. A `start_req` in this window is ignored.
- R7: `ready` rises in the cycle after the deselect interval ends, and a start request in that cycle is accepted.
- R8: A field value of 0 gives an interval of exactly one cycle.
- R9: A timing register write in the same cycle as an acceptance takes effect after that cycle. That operation's setup uses the old value, and its hold and deselect use the new values.
- R10: `sclk_en` is never high unless a select line is low.
- R11: `last_bit` has no effect outside the clock-enabled interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 12 | Timing register value: hold [11:8], setup [7:4], deselect [3:0] |
| start_req | input | 1 | Start request from the phase sequencer |
| cs_index | input | 1 | Device select index, sampled on acceptance |
| last_bit | input | 1 | Last-bit flag from the phase sequencer |
| sclk_en | output | 1 | Serial clock enable |
| ready | output | 1 | Ready to accept a new operation |
| cs_n | output | 2 | Active-low chip selects |

## Verification
Two functions can fall in the same cycle: a write to the timing register and the loading of an interval count when a start request is accepted. The bench provokes this by raising the write strobe and the start request in one cycle with different field values. The scoreboard expects the setup length of that operation to follow the old value and the hold and deselect lengths to follow the new one. A second collision is a start request held through the deselect window. It is judged by the select lines staying high and `ready` staying low until the deselect count expires.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int CST_FIELD_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DESEL  = 3'd4
  } cst_state_e;

  // Reload value for a phase counter: an interval of max(v,1) cycles
  function automatic logic [CST_FIELD_W-1:0] cst_reload(input logic [CST_FIELD_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/cst_timing_reg.sv
module cst_timing_reg #(
  parameter int FIELD_W   = 4,
  parameter int RST_HOLD  = 6,
  parameter int RST_SETUP = 6,
  parameter int RST_DESEL = 15,
  localparam int CFG_W    = 3 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CFG_W-1:0]   wdata,
  output logic [FIELD_W-1:0] hold_q,
  output logic [FIELD_W-1:0] setup_q,
  output logic [FIELD_W-1:0] desel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= FIELD_W'(RST_HOLD);
      setup_q <= FIELD_W'(RST_SETUP);
      desel_q <= FIELD_W'(RST_DESEL);
    end else if (we) begin
      hold_q  <= wdata[3*FIELD_W-1:2*FIELD_W];
      setup_q <= wdata[2*FIELD_W-1:FIELD_W];
      desel_q <= wdata[FIELD_W-1:0];
    end
  end
endmodule

// File: rtl/cst_phase_cnt.sv
module cst_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cst_seq.sv
module cst_seq
  import cst_pkg::*;
#(
  parameter int FIELD_W = CST_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               last_bit,
  input  logic               cnt_expired,
  input  logic [FIELD_W-1:0] setup_v,
  input  logic [FIELD_W-1:0] hold_v,
  input  logic [FIELD_W-1:0] desel_v,
  output cst_state_e         state_q,
  output logic               cnt_load,
  output logic [FIELD_W-1:0] cnt_val,
  output logic               accept
);
  cst_state_e state_d;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        accept   = 1'b1;
        state_d  = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = cst_reload(setup_v);
      end
      ST_SETUP: if (cnt_expired) state_d = ST_ACTIVE;
      ST_ACTIVE: if (last_bit) begin
        state_d  = ST_HOLD;
        cnt_load = 1'b1;
        cnt_val  = cst_reload(hold_v);
      end
      ST_HOLD: if (cnt_expired) begin
        state_d  = ST_DESEL;
        cnt_load = 1'b1;
        cnt_val  = cst_reload(desel_v);
      end
      ST_DESEL: if (cnt_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/cst_gen.sv
module cst_gen
  import cst_pkg::*;
#(
  parameter int CS_COUNT  = 2,
  parameter int RST_HOLD  = 6,
  parameter int RST_SETUP = 6,
  parameter int RST_DESEL = 15,
  localparam int FIELD_W  = CST_FIELD_W,
  localparam int CFG_W    = 3 * FIELD_W,
  localparam int IDX_W    = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                start_req,
  input  logic [IDX_W-1:0]    cs_index,
  input  logic                last_bit,
  output logic                sclk_en,
  output logic                ready,
  output logic [CS_COUNT-1:0] cs_n
);
  logic [FIELD_W-1:0] hold_v, setup_v, desel_v;
  logic               cnt_load, cnt_expired, accept;
  logic [FIELD_W-1:0] cnt_val;
  cst_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               cs_window;

  cst_timing_reg #(
    .FIELD_W(FIELD_W), .RST_HOLD(RST_HOLD),
    .RST_SETUP(RST_SETUP), .RST_DESEL(RST_DESEL)
  ) treg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .hold_q(hold_v), .setup_q(setup_v), .desel_q(desel_v)
  );

  cst_seq #(.FIELD_W(FIELD_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .last_bit(last_bit),
    .cnt_expired(cnt_expired), .setup_v(setup_v), .hold_v(hold_v),
    .desel_v(desel_v), .state_q(state_q), .cnt_load(cnt_load),
    .cnt_val(cnt_val), .accept(accept)
  );

  cst_phase_cnt #(.W(FIELD_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .expired(cnt_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (accept) idx_q <= cs_index;
  end

  assign cs_window = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) ||
                     (state_q == ST_HOLD);
  assign sclk_en   = (state_q == ST_ACTIVE);
  assign ready     = (state_q == ST_IDLE);

  for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
    assign cs_n[g] = !(cs_window && (idx_q == IDX_W'(g)));
  end
endmodule

// File: rtl/cst_gen_chk.sv
module cst_gen_chk #(
  parameter int CS_COUNT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_req,
  input logic                last_bit,
  input logic                sclk_en,
  input logic                ready,
  input logic [CS_COUNT-1:0] cs_n
);
  // R10
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> !(&cs_n));

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2
  accept_asserts_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && ready) |=> (!ready && !(&cs_n)));

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((&cs_n) && !sclk_en));

  // R6
  desel_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |-> !ready);

  // R4
  sclk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_en) |-> $past(last_bit));

  // R2
  cs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));
endmodule

bind cst_gen cst_gen_chk #(.CS_COUNT(CS_COUNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .last_bit(last_bit),
  .sclk_en(sclk_en), .ready(ready), .cs_n(cs_n)
);

// File: tb/cst_gen_tb_top.sv
module cst_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_wdata = '0;
  logic        start_req = 1'b0;
  logic [0:0]  cs_index = '0;
  logic        last_bit = 1'b0;
  logic        sclk_en, ready;
  logic [1:0]  cs_n;

  always #4 clk = ~clk;

  cst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start_req(start_req), .cs_index(cs_index), .last_bit(last_bit),
    .sclk_en(sclk_en), .ready(ready), .cs_n(cs_n)
  );

  typedef struct {
    logic [1:0] cs;
    logic       sclk;
    logic       rdy;
    int         req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push(logic [1:0] c, logic s, logic r, int req);
    exp_t e;
    e.cs = c; e.sclk = s; e.rdy = r; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cs_n !== e.cs || sclk_en !== e.sclk || ready !== e.rdy) begin
          fails++;
          $display("FAIL R%0d: cs_n=%b sclk_en=%b ready=%b expected cs_n=%b sclk_en=%b ready=%b",
                   e.req, cs_n, sclk_en, ready, e.cs, e.sclk, e.rdy);
        end
      end
    end
  end

  task automatic write_cfg(logic [11:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // Driver: one operation; s/h/d are the field values the bench expects in use
  task automatic run_op(int idx, int a, int s, int h, int d,
                        bit wr, logic [11:0] wd, bit poke);
    logic [1:0] sel;
    int es, eh, ed, total;
    sel = (idx == 0) ? 2'b10 : 2'b01;
    es = eff(s); eh = eff(h); ed = eff(d);  // R8
    total = es + a + eh + ed + 1;
    @(posedge clk); #1;
    start_req = 1'b1; cs_index = idx[0:0];
    if (wr) begin cfg_we = 1'b1; cfg_wdata = wd; end  // R9 collision
    push(2'b11, 1'b0, 1'b1, 7);                                // R7 ready before accept
    for (int c = 0; c < es; c++) push(sel, 1'b0, 1'b0, 3);    // R3
    for (int c = 0; c < a; c++)  push(sel, 1'b1, 1'b0, 4);    // R4
    for (int c = 0; c < eh; c++) push(sel, 1'b0, 1'b0, 5);    // R5
    for (int c = 0; c < ed; c++) push(2'b11, 1'b0, 1'b0, 6);  // R6
    push(2'b11, 1'b0, 1'b1, 7);                                // R7
    for (int c = 1; c <= total; c++) begin
      @(posedge clk); #1;
      cfg_we    = 1'b0;
      // R11: last_bit pulsed during setup must be ignored
      last_bit  = (c == es + a) || (poke && c == 1 && es >= 2);
      // R6: start held during deselect must be ignored
      start_req = poke && (c > es + a + eh) && (c <= es + a + eh + ed);
    end
    start_req = 1'b0;
    last_bit  = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cs_n !== 2'b11 || sclk_en !== 1'b0 || ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: cs_n=%b sclk_en=%b ready=%b expected cs_n=11 sclk_en=0 ready=1",
               cs_n, sclk_en, ready);
    end
    // R1 default timing, R2 device 0
    run_op(0, 3, 6, 6, 15, 1'b0, 12'h000, 1'b0);
    // R2 device 1 with programmed values
    write_cfg(12'h234);
    run_op(1, 1, 3, 2, 4, 1'b0, 12'h000, 1'b0);
    // R8 all fields zero
    write_cfg(12'h000);
    run_op(0, 2, 0, 0, 0, 1'b0, 12'h000, 1'b0);
    // R6 and R11 pokes
    write_cfg(12'h532);
    run_op(1, 4, 3, 5, 2, 1'b0, 12'h000, 1'b1);
    // R9 write in the accept cycle: setup old (3), hold 1, deselect 4 new
    run_op(0, 2, 3, 1, 4, 1'b1, 12'h174, 1'b0);
    // R7 back-to-back with the same values
    run_op(1, 1, 7, 1, 4, 1'b0, 12'h000, 1'b0);
    // maximum fields
    write_cfg(12'hFFF);
    run_op(1, 1, 15, 15, 15, 1'b0, 12'h000, 1'b1);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule